// File: doc/BRIEF.md
# Counter-Based Random Word Sequencer

This block is the control front end of a counter-based random number generator. It keeps a 64-bit key, which is the seed, and a 128-bit counter. The upper half of the counter names an independent stream and the lower half is the position within that stream. Software-side logic loads a seed and stream index, or moves the position forward by any 64-bit amount. Consumers draw 32-bit random words one at a time.

Random material comes in 128-bit blocks from a separate mixing core, which is reached over a request/response interface. When the four-word output buffer is used up, the sequencer sends the current counter, key and round count to the core. It then steps the counter by one and stalls until the block comes back. The four words of each block are handed out in turn, so the mixing core is used on one request in four. A pending seed or skip command waits until any block generation in flight has finished.

Top module: `rng_word_sequencer`

## Requirements
- R1: After reset the key equals 64'h00003D30F19CD101 (decimal 67280421310721), the counter is zero, the word index is 0, and `cmd_ready` and `word_req_ready` are high while `word_valid` and `mix_req_valid` are low.
- R2: A command accepted with `cmd_kind`=0 loads the key from `cmd_arg_a` (key bits 31:0 from seed bits 31:0, key bits 63:32 from seed bits 63:32). It clears counter bits 63:0, puts `cmd_arg_b` into counter bits 127:64, and returns the word index to 0, so the next word request generates a fresh block.
- R3: A command accepted with `cmd_kind`=1 adds the zero-extended `cmd_arg_a` to the 128-bit counter. Carry from bit 63 ripples into bits 95:64, and from there into bits 127:96.
- R4: A word request accepted at word index 0 raises `mix_req_valid`, carrying the counter on `mix_counter` (32-bit counter word k at bits 32k+31:32k) and the key on `mix_key`. When the core accepts, the 128-bit counter increments by one with full ripple carry.
- R5: Words are returned in the order `mix_rsp_block` bits 31:0, 63:32, 95:64, 127:96, with the index advancing modulo 4. Only a request made at index 0 contacts the mixing core.
- R6: `mix_rounds` equals `cfg_rounds` sampled when the generating request is accepted, and equals 10 when `cfg_rounds` is 0.
- R7: From a generating request until the block response arrives, `word_req_ready` and `cmd_ready` stay low. While `mix_req_ready` is low, `mix_req_valid` stays high and its counter, key and rounds stay stable.
- R8: A command presented while a generation is pending is held off until the sequencer is idle again, and is then applied. When a command and a word request are both presented while idle, the command is taken and `word_req_ready` is low.
- R9: A skip does not discard words already buffered. Those words are still returned, and the skip shows only in the counter of the next generated block.
- R10: A buffered word appears on `word_data` with a one-cycle `word_valid` pulse one cycle after its request is accepted. A freshly generated word appears one cycle after `mix_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rounds | input | 6 | Mixing round count, 0 selects the default of 10 |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_kind | input | 1 | 0 = seed load, 1 = skip ahead |
| cmd_arg_a | input | 64 | Seed (load) or offset (skip) |
| cmd_arg_b | input | 64 | Stream index (load) |
| word_req_valid | input | 1 | Consumer requests one word |
| word_req_ready | output | 1 | Word request can be accepted |
| word_valid | output | 1 | One-cycle pulse: `word_data` holds a word |
| word_data | output | 32 | Random word |
| mix_req_valid | output | 1 | Block request to mixing core |
| mix_req_ready | input | 1 | Mixing core accepts request |
| mix_counter | output | 128 | Counter sent with the request |
| mix_key | output | 64 | Key sent with the request |
| mix_rounds | output | 6 | Round count sent with the request |
| mix_rsp_valid | input | 1 | Mixing core returns a block |
| mix_rsp_block | input | 128 | Returned 128-bit block |

## Verification
A buffered word is due at the first falling edge after the accepting rising edge. A generating request shows `mix_req_valid` at that same falling edge, and the resulting word shows one edge after `mix_rsp_valid` is taken. The bench stands in for the mixing core and drives every input on falling edges, so it knows exactly which rising edge consumes each one. It samples each result at the falling edge where that latency says it is due. During the stall cycles of random length it checks that the request payload is stable and that both ready signals stay low. Commands are checked through the counter and key of the next block request rather than by looking inside the design.

// File: rtl/rngseq_pkg.sv
package rngseq_pkg;
    localparam int WORD_W   = 32;
    localparam int LANES    = 4;
    localparam int BLOCK_W  = WORD_W * LANES;
    localparam int KEY_W    = 2 * WORD_W;
    localparam int HALF_W   = BLOCK_W / 2;
    localparam int IDX_W    = $clog2(LANES);
    localparam int RND_W    = 6;
    localparam int DEFAULT_ROUNDS = 10;
    localparam logic [KEY_W-1:0] DEFAULT_SEED = 64'h0000_3D30_F19C_D101;

    typedef logic [BLOCK_W-1:0] block_t;
    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef enum logic {
        CMD_SEED = 1'b0,
        CMD_SKIP = 1'b1
    } cmd_kind_e;

    function automatic word_t lane_of(block_t b, idx_t i);
        return b[i*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/rngseq_state.sv
module rngseq_state
    import rngseq_pkg::*;
#(
    parameter key_t SEED_DEFAULT = DEFAULT_SEED
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_seed,
    input  key_t                seed_in,
    input  logic [HALF_W-1:0]   stream_in,
    input  logic                do_skip,
    input  logic [HALF_W-1:0]   skip_in,
    input  logic                do_step,
    output block_t              ctr_q,
    output key_t                key_q
);
    block_t           addend;
    block_t           sum;
    logic [LANES:0]   carry;

    assign addend   = do_skip ? {{(BLOCK_W-HALF_W){1'b0}}, skip_in} : block_t'(1);
    assign carry[0] = 1'b0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W:0] lane_sum;
        assign lane_sum = {1'b0, ctr_q[g*WORD_W +: WORD_W]}
                        + {1'b0, addend[g*WORD_W +: WORD_W]}
                        + {{WORD_W{1'b0}}, carry[g]};
        assign sum[g*WORD_W +: WORD_W] = lane_sum[WORD_W-1:0];
        assign carry[g+1]              = lane_sum[WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= SEED_DEFAULT;
            ctr_q <= '0;
        end else if (load_seed) begin
            key_q <= seed_in;
            ctr_q <= {stream_in, {HALF_W{1'b0}}};
        end else if (do_skip || do_step) begin
            ctr_q <= sum;
        end
    end

    assert_seed_split_R2: assert property (@(posedge clk) disable iff (rst)
        load_seed |=> (key_q == $past(seed_in)) && (ctr_q[HALF_W-1:0] == '0)
                      && (ctr_q[BLOCK_W-1:HALF_W] == $past(stream_in)));

    assert_skip_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (do_skip && !load_seed) |=> ctr_q == $past(ctr_q) + {{(BLOCK_W-HALF_W){1'b0}}, $past(skip_in)});

    assert_step_ripple_R4: assert property (@(posedge clk) disable iff (rst)
        (do_step && !do_skip && !load_seed) |=> ctr_q == $past(ctr_q) + block_t'(1));
endmodule

// File: rtl/rngseq_wordbuf.sv
module rngseq_wordbuf
    import rngseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    fill,
    input  block_t  fill_block,
    input  logic    take,
    output idx_t    idx_q,
    output logic    vld_q,
    output word_t   word_q
);
    word_t lane_q [LANES];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            vld_q  <= 1'b0;
            word_q <= '0;
            for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
        end else begin
            vld_q <= 1'b0;
            if (clear) begin
                idx_q <= '0;
            end else if (fill) begin
                for (int i = 0; i < LANES; i++) lane_q[i] <= lane_of(fill_block, idx_t'(i));
                word_q <= lane_of(fill_block, '0);
                vld_q  <= 1'b1;
                idx_q  <= idx_t'(1);
            end else if (take) begin
                word_q <= lane_q[idx_q];
                vld_q  <= 1'b1;
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    assert_idx_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !fill && !clear) |=> vld_q && (idx_q == idx_t'($past(idx_q) + 1'b1)));

    assert_fill_first_R10: assert property (@(posedge clk) disable iff (rst)
        (fill && !clear) |=> vld_q && (word_q == $past(fill_block[WORD_W-1:0])) && (idx_q == idx_t'(1)));

    assert_clear_index_R2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (idx_q == '0) && !vld_q);
endmodule

// File: rtl/rng_word_sequencer.sv
module rng_word_sequencer
    import rngseq_pkg::*;
#(
    parameter key_t SEED_DEFAULT   = DEFAULT_SEED,
    parameter int   ROUNDS_DEFAULT = DEFAULT_ROUNDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RND_W-1:0]    cfg_rounds,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_kind,
    input  logic [KEY_W-1:0]    cmd_arg_a,
    input  logic [HALF_W-1:0]   cmd_arg_b,
    input  logic                word_req_valid,
    output logic                word_req_ready,
    output logic                word_valid,
    output logic [WORD_W-1:0]   word_data,
    output logic                mix_req_valid,
    input  logic                mix_req_ready,
    output logic [BLOCK_W-1:0]  mix_counter,
    output logic [KEY_W-1:0]    mix_key,
    output logic [RND_W-1:0]    mix_rounds,
    input  logic                mix_rsp_valid,
    input  logic [BLOCK_W-1:0]  mix_rsp_block
);
    seq_state_e        state_q, state_d;
    logic [RND_W-1:0]  rounds_q;
    logic [RND_W-1:0]  rounds_eff;
    idx_t              idx;
    logic              cmd_fire, word_fire, gen_start, take, step, fill;
    logic              load_seed, do_skip;
    block_t            ctr;
    key_t              key;

    assign rounds_eff     = (cfg_rounds == '0) ? RND_W'(ROUNDS_DEFAULT) : cfg_rounds;

    assign cmd_ready      = (state_q == ST_IDLE);
    assign word_req_ready = (state_q == ST_IDLE) && !cmd_valid;
    assign cmd_fire       = cmd_valid && cmd_ready;
    assign word_fire      = word_req_valid && word_req_ready;
    assign gen_start      = word_fire && (idx == '0);
    assign take           = word_fire && (idx != '0);
    assign load_seed      = cmd_fire && (cmd_kind == CMD_SEED);
    assign do_skip        = cmd_fire && (cmd_kind == CMD_SKIP);
    assign mix_req_valid  = (state_q == ST_ISSUE);
    assign step           = mix_req_valid && mix_req_ready;
    assign fill           = (state_q == ST_WAIT) && mix_rsp_valid;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (gen_start)     state_d = ST_ISSUE;
            ST_ISSUE: if (mix_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mix_rsp_valid) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            rounds_q <= RND_W'(ROUNDS_DEFAULT);
        end else begin
            state_q <= state_d;
            if (gen_start) rounds_q <= rounds_eff;
        end
    end

    rngseq_state #(
        .SEED_DEFAULT (SEED_DEFAULT)
    ) i_state (
        .clk       (clk),
        .rst       (rst),
        .load_seed (load_seed),
        .seed_in   (cmd_arg_a),
        .stream_in (cmd_arg_b),
        .do_skip   (do_skip),
        .skip_in   (cmd_arg_a[HALF_W-1:0]),
        .do_step   (step),
        .ctr_q     (ctr),
        .key_q     (key)
    );

    rngseq_wordbuf i_wordbuf (
        .clk        (clk),
        .rst        (rst),
        .clear      (load_seed),
        .fill       (fill),
        .fill_block (mix_rsp_block),
        .take       (take),
        .idx_q      (idx),
        .vld_q      (word_valid),
        .word_q     (word_data)
    );

    assign mix_counter = ctr;
    assign mix_key     = key;
    assign mix_rounds  = rounds_q;

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mix_req_valid && !mix_req_ready) |=> mix_req_valid && $stable(mix_counter)
                                              && $stable(mix_key) && $stable(mix_rounds));

    assert_closed_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (mix_req_valid || state_q == ST_WAIT) |-> !cmd_ready && !word_req_ready);

    assert_rounds_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        mix_req_valid |-> mix_rounds != '0);

    assert_step_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (mix_req_valid && mix_req_ready) |=> mix_counter == $past(mix_counter) + block_t'(1));

    assert_cmd_priority_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !word_req_ready);

    assert_no_word_pending_R10: assert property (@(posedge clk) disable iff (rst)
        mix_req_valid |-> !word_valid);
endmodule

// File: tb/test_rng_word_sequencer.sv
module test_rng_word_sequencer;
    import rngseq_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [RND_W-1:0]   cfg_rounds = '0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic               cmd_kind = 1'b0;
    logic [KEY_W-1:0]   cmd_arg_a = '0;
    logic [HALF_W-1:0]  cmd_arg_b = '0;
    logic               word_req_valid = 1'b0;
    logic               word_req_ready;
    logic               word_valid;
    logic [WORD_W-1:0]  word_data;
    logic               mix_req_valid;
    logic               mix_req_ready = 1'b0;
    logic [BLOCK_W-1:0] mix_counter;
    logic [KEY_W-1:0]   mix_key;
    logic [RND_W-1:0]   mix_rounds;
    logic               mix_rsp_valid = 1'b0;
    logic [BLOCK_W-1:0] mix_rsp_block = '0;

    int total = 0;
    int bad   = 0;

    logic [KEY_W-1:0]   m_key;
    logic [BLOCK_W-1:0] m_ctr;
    logic [BLOCK_W-1:0] m_buf;
    int                 m_idx;

    always #4 clk = ~clk;

    rng_word_sequencer i_rng_word_sequencer (
        .clk(clk), .rst(rst), .cfg_rounds(cfg_rounds),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_arg_a(cmd_arg_a), .cmd_arg_b(cmd_arg_b),
        .word_req_valid(word_req_valid), .word_req_ready(word_req_ready),
        .word_valid(word_valid), .word_data(word_data),
        .mix_req_valid(mix_req_valid), .mix_req_ready(mix_req_ready),
        .mix_counter(mix_counter), .mix_key(mix_key), .mix_rounds(mix_rounds),
        .mix_rsp_valid(mix_rsp_valid), .mix_rsp_block(mix_rsp_block)
    );

    function automatic logic [BLOCK_W-1:0] mix_model(logic [BLOCK_W-1:0] c, logic [KEY_W-1:0] k,
                                                     logic [RND_W-1:0] r);
        logic [BLOCK_W-1:0] v;
        v = c ^ {k, k} ^ {4{{(WORD_W-RND_W){1'b0}}, r}};
        return {v[100:0], v[127:101]} ^ 128'h5A5A_0F0F_3C3C_9696_A5A5_F0F0_C3C3_6969;
    endfunction

    function automatic logic [RND_W-1:0] exp_rounds(logic [RND_W-1:0] c);
        return (c == '0) ? RND_W'(DEFAULT_ROUNDS) : c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [BLOCK_W-1:0] act,
                       input logic [BLOCK_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic kind, input logic [KEY_W-1:0] a, input logic [HALF_W-1:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_arg_a = a; cmd_arg_b = b;
        word_req_valid = 1'b1;
        #1;
        chk(!word_req_ready && cmd_ready, "R8 command wins over word request",
            {126'b0, word_req_ready, cmd_ready}, 128'h1);
        @(negedge clk);
        cmd_valid = 1'b0; word_req_valid = 1'b0;
        if (kind == CMD_SEED) begin
            m_key = a; m_ctr = {b, 64'b0}; m_idx = 0;
        end else begin
            m_ctr = m_ctr + {64'b0, a};
        end
    endtask

    task automatic do_word(input bit hold_cmd, input logic [HALF_W-1:0] hold_off);
        logic [WORD_W-1:0]  exp;
        logic [BLOCK_W-1:0] blk;
        logic [RND_W-1:0]   er;
        bit                 gen;
        int                 stall;
        @(negedge clk);
        chk(word_req_ready, "R7 ready while idle", {127'b0, word_req_ready}, 128'h1);
        word_req_valid = 1'b1;
        er = exp_rounds(cfg_rounds);
        @(negedge clk);
        word_req_valid = 1'b0;
        gen = (m_idx == 0);
        if (gen) begin
            chk(mix_req_valid, "R5 mix request at index 0", {127'b0, mix_req_valid}, 128'h1);
            chk(mix_counter == m_ctr, "R4 request counter", mix_counter, m_ctr);
            chk(mix_key == m_key, "R4 request key", {64'b0, mix_key}, {64'b0, m_key});
            chk(mix_rounds == er, "R6 request rounds", {122'b0, mix_rounds}, {122'b0, er});
            if (hold_cmd) begin
                cmd_valid = 1'b1; cmd_kind = CMD_SKIP; cmd_arg_a = hold_off;
            end
            stall = $urandom % 3;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(mix_req_valid && mix_counter == m_ctr, "R7 request held stable", mix_counter, m_ctr);
                chk(!word_req_ready && !cmd_ready, "R7 readies low while issuing",
                    {126'b0, word_req_ready, cmd_ready}, 128'h0);
            end
            mix_req_ready = 1'b1;
            @(negedge clk);
            mix_req_ready = 1'b0;
            blk = mix_model(m_ctr, m_key, er);
            m_ctr = m_ctr + 128'd1;
            stall = $urandom % 3;
            for (int s = 0; s < stall; s++) begin
                chk(!mix_req_valid && !cmd_ready && !word_req_ready && !word_valid,
                    "R8 held off while waiting",
                    {124'b0, mix_req_valid, cmd_ready, word_req_ready, word_valid}, 128'h0);
                @(negedge clk);
            end
            mix_rsp_valid = 1'b1; mix_rsp_block = blk;
            @(negedge clk);
            mix_rsp_valid = 1'b0;
            m_buf = blk; exp = blk[31:0]; m_idx = 1;
        end else begin
            chk(!mix_req_valid, "R5 no mix request off index 0", {127'b0, mix_req_valid}, 128'h0);
            exp = m_buf[32*m_idx +: 32];
            m_idx = (m_idx + 1) % 4;
        end
        chk(word_valid && word_data == exp, "R10 word due one cycle later / R5 order",
            {95'b0, word_valid, word_data}, {95'b0, 1'b1, exp});
        if (hold_cmd && gen) begin
            chk(cmd_ready && !word_req_ready, "R8 held command taken when idle",
                {126'b0, cmd_ready, word_req_ready}, 128'h2);
            @(negedge clk);
            cmd_valid = 1'b0;
            m_ctr = m_ctr + {64'b0, hold_off};
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_key = DEFAULT_SEED; m_ctr = '0; m_buf = '0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready && word_req_ready && !word_valid && !mix_req_valid, "R1 reset handshake state",
            {124'b0, cmd_ready, word_req_ready, word_valid, mix_req_valid}, 128'hC);
        chk(mix_counter == '0, "R1 reset counter", mix_counter, '0);
        chk(mix_key == DEFAULT_SEED, "R1 reset key", {64'b0, mix_key}, {64'b0, DEFAULT_SEED});

        // R1 and R6: default seed and default rounds over two blocks
        for (int i = 0; i < 5; i++) do_word(1'b0, '0);

        // R4: full ripple wrap of the counter, R9: skip mid-buffer
        cfg_rounds = 6'd7;
        do_cmd(CMD_SEED, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
        do_cmd(CMD_SKIP, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        do_word(1'b0, '0);
        chk(m_ctr == '0, "R4 model wrap sanity", m_ctr, '0);
        do_word(1'b0, '0);
        do_cmd(CMD_SKIP, 64'd1, '0);
        do_word(1'b0, '0);
        do_word(1'b0, '0);
        do_word(1'b0, '0);

        // R3: carry into word 2, then word 2 wrapping into word 3
        do_cmd(CMD_SEED, 64'h1, 64'h0000_0000_0000_0005);
        do_cmd(CMD_SKIP, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        do_cmd(CMD_SKIP, 64'd1, '0);
        do_word(1'b0, '0);
        do_cmd(CMD_SEED, 64'h2, 64'h0000_0000_FFFF_FFFF);
        do_cmd(CMD_SKIP, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        do_cmd(CMD_SKIP, 64'd1, '0);
        do_word(1'b0, '0);

        // R2: a seed load mid-buffer forces a fresh block
        do_word(1'b0, '0);
        do_cmd(CMD_SEED, 64'hDEAD_BEEF_0000_1111, 64'h42);
        do_word(1'b0, '0);

        // R8: skip held off during generation
        do_cmd(CMD_SEED, 64'h77, 64'h9);
        do_word(1'b1, 64'h1234_5678);
        for (int i = 0; i < 4; i++) do_word(1'b0, '0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom % 12;
            if (r < 8) begin
                do_word(1'b0, '0);
            end else if (r == 8) begin
                logic [63:0] off;
                off = ($urandom % 2 == 0) ? {32'b0, $urandom} : {$urandom, $urandom};
                do_cmd(CMD_SKIP, off, '0);
            end else if (r == 9) begin
                do_cmd(CMD_SEED, {$urandom, $urandom}, {$urandom, $urandom});
            end else if (r == 10) begin
                cfg_rounds = RND_W'($urandom % 16);
            end else if (m_idx == 0) begin
                do_word(1'b1, {$urandom, $urandom});
            end else begin
                do_word(1'b0, '0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule